// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside an 8-bit processor core and decides when the core leaves its program to enter an exception handler. It watches three request sources: a reset request, a non-maskable request (NMI) and a maskable level request (IRQ). It also watches a software-break request that the core raises when it finishes a break instruction. At an instruction boundary it picks the most urgent eligible source. It then runs a fixed seven-cycle entry sequence. That sequence pushes the return address and status onto the stack page, sets the interrupt-disable flag, reads the two-byte handler address from a source-specific vector slot, and hands the new program counter to the core.

The NMI source can be switched off by a bit taken from the video controller's control register. When that bit is clear, an edge on the NMI line is dropped. The IRQ source is masked by the core's interrupt-disable flag. A software break ignores that mask, uses the same vector as IRQ, and is told apart from IRQ only by a break marker in the pushed status byte. A reset entry writes nothing to the stack and reinitialises the stack pointer.

Entry sequence states, each lasting one cycle: `ST_IDLE` (waiting, busy low), `ST_ENT1` and `ST_ENT2` (internal cycles), `ST_PUSH_HI` (push PC high byte), `ST_PUSH_LO` (push PC low byte), `ST_PUSH_ST` (push status), `ST_VEC_LO` (read vector low byte, pulse set-I), `ST_VEC_HI` (read vector high byte, load PC). The transition out of `ST_IDLE` is taken on acceptance. Every other state always steps to the next in the list, and `ST_VEC_HI` returns to `ST_IDLE`.

Top module: `intr_entry_seq`

## Requirements
- R1: When several sources are eligible at the same time, reset is taken before NMI, NMI before IRQ, and IRQ before software break. A source that is not taken stays pending.
- R2: The vector pair read is at addresses FFFA/FFFB for NMI, FFFC/FFFD for reset, and FFFE/FFFF for both IRQ and break. The low byte is read first. `pc_new` equals {high byte, low byte} while `pc_load` is high.
- R3: IRQ is not taken while `flag_i` is 1. A software break is taken whatever `flag_i` holds.
- R4: A rising edge on `req_nmi` is latched only if `nmi_en` is 1 on that cycle. Each latched edge gives exactly one NMI entry, even if the line stays high.
- R5: NMI, IRQ and break are accepted only in an idle cycle with `insn_done` high. A pending reset is accepted in any idle cycle.
- R6: After acceptance, `busy` is high for exactly 7 cycles. Pushes happen in cycles 3 to 5, vector reads in cycles 6 and 7, and `pc_load` pulses in cycle 7.
- R7: Pushes go out in the order PC high, PC low, status, to address 0x0100 + `sp_out`. `sp_out` drops by one after each push and wraps from 0x00 to 0xFF.
- R8: In the pushed status byte, bit 5 is 1 and bit 4 is 1 only for a software break. All other bits copy `stat_in` as it was at acceptance.
- R9: A reset entry makes no pushes and leaves `sp_out` at 0xFD. When `rst_n` is asserted, `sp_out` is 0xFD and `busy` is 0. When `rst_n` is released, a reset entry follows.
- R10: `set_i` is a one-cycle pulse in cycle 6 of every entry, and it is never high at any other time.
- R11: A reset or NMI request that arrives while an entry is running is held and taken at the next eligible idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| req_reset | input | 1 | Reset request, latched until serviced |
| req_nmi | input | 1 | Non-maskable request line, edge sensitive |
| req_irq | input | 1 | Maskable request line, level sensitive |
| flag_i | input | 1 | Core interrupt-disable flag |
| nmi_en | input | 1 | NMI enable bit from video control register |
| insn_done | input | 1 | Instruction boundary strobe |
| brk_req | input | 1 | Software break request, valid with insn_done |
| pc_in | input | 16 | Current program counter of the core |
| stat_in | input | 8 | Current status byte of the core |
| push_en | output | 1 | Stack write strobe |
| push_addr | output | 16 | Stack write address |
| push_data | output | 8 | Stack write data |
| sp_out | output | 8 | Stack pointer |
| set_i | output | 1 | Pulse to set the interrupt-disable flag |
| vec_rd | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector read address |
| vec_data | input | 8 | Vector read data, same-cycle |
| busy | output | 1 | Entry sequence in progress |
| pc_load | output | 1 | Load strobe for the new PC |
| pc_new | output | 16 | Handler address |

## Verification
The assertions assume that `vec_data` is valid in the same cycle as `vec_rd`. They also assume that `insn_done` and `brk_req` are strobes the core raises only between instructions, never while `busy` is high. The bench keeps to these rules: it raises `insn_done` only in idle cycles, returns `brk_req` low together with `insn_done`, and answers vector reads from a combinational model. NMI pulses, reset pulses and mask changes are applied on falling edges, one full cycle before the boundary strobe, so every latched request is in place before the cycle in which it is judged.

// File: rtl/intr_pkg.sv
package intr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENT1,
        ST_ENT2,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_VEC_LO,
        ST_VEC_HI
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_RESET,
        SRC_NMI,
        SRC_IRQ,
        SRC_BRK
    } intr_src_t;

endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_reset,
    input  logic      req_nmi,
    input  logic      req_irq,
    input  logic      flag_i,
    input  logic      nmi_en,
    input  logic      insn_done,
    input  logic      brk_req,
    input  logic      idle,
    output logic      accept,
    output intr_src_t sel_src
);

    logic rst_pend;
    logic nmi_pend;
    logic nmi_q;
    logic nmi_edge;
    logic irq_ok;
    logic any_soft;

    assign nmi_edge = req_nmi & ~nmi_q & nmi_en;
    assign irq_ok   = req_irq & ~flag_i;
    assign any_soft = nmi_pend | irq_ok | brk_req;

    // Fixed priority: reset, NMI, IRQ, software break
    always_comb begin
        if (rst_pend)      sel_src = SRC_RESET;
        else if (nmi_pend) sel_src = SRC_NMI;
        else if (irq_ok)   sel_src = SRC_IRQ;
        else               sel_src = SRC_BRK;
    end

    assign accept = idle & (rst_pend | (insn_done & any_soft));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pend <= 1'b1;
            nmi_pend <= 1'b0;
            nmi_q    <= 1'b0;
        end else begin
            nmi_q <= req_nmi;
            if (req_reset)
                rst_pend <= 1'b1;
            else if (accept && sel_src == SRC_RESET)
                rst_pend <= 1'b0;
            if (nmi_edge)
                nmi_pend <= 1'b1;
            else if (accept && sel_src == SRC_NMI)
                nmi_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/intr_stack_ptr.sv
module intr_stack_ptr #(
    parameter int               SP_W    = 8,
    parameter logic [SP_W-1:0]  SP_INIT = 8'hFD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec,
    input  logic            load_init,
    output logic [SP_W-1:0] sp
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= SP_INIT;
        else if (load_init)
            sp <= SP_INIT;
        else if (dec)
            sp <= sp - 1'b1;
    end

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_pkg::*;
#(
    parameter int               DW         = 8,
    parameter int               AW         = 16,
    parameter logic [DW-1:0]    STACK_PAGE = 8'h01,
    parameter logic [DW-1:0]    SP_INIT    = 8'hFD,
    parameter logic [AW-1:0]    VEC_NMI    = 16'hFFFA,
    parameter logic [AW-1:0]    VEC_RESET  = 16'hFFFC,
    parameter logic [AW-1:0]    VEC_IRQ    = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_reset,
    input  logic          req_nmi,
    input  logic          req_irq,
    input  logic          flag_i,
    input  logic          nmi_en,
    input  logic          insn_done,
    input  logic          brk_req,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] stat_in,
    output logic          push_en,
    output logic [AW-1:0] push_addr,
    output logic [DW-1:0] push_data,
    output logic [DW-1:0] sp_out,
    output logic          set_i,
    output logic          vec_rd,
    output logic [AW-1:0] vec_addr,
    input  logic [DW-1:0] vec_data,
    output logic          busy,
    output logic          pc_load,
    output logic [AW-1:0] pc_new
);

    localparam int BRK_BIT = 4;
    localparam int ONE_BIT = 5;

    seq_state_t state, state_nx;
    intr_src_t  sel_src, src_q;
    logic       accept;
    logic       idle;
    logic       sp_dec;
    logic       sp_init;

    logic [AW-1:0] pc_q;
    logic [1:0]    st_hi_q;
    logic [3:0]    st_lo_q;
    logic [DW-1:0] vec_lo_q;
    logic [DW-1:0] pushed_status;
    logic [AW-1:0] vec_base;

    assign idle = (state == ST_IDLE);

    intr_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_reset (req_reset),
        .req_nmi   (req_nmi),
        .req_irq   (req_irq),
        .flag_i    (flag_i),
        .nmi_en    (nmi_en),
        .insn_done (insn_done),
        .brk_req   (brk_req),
        .idle      (idle),
        .accept    (accept),
        .sel_src   (sel_src)
    );

    intr_stack_ptr #(
        .SP_W    (DW),
        .SP_INIT (SP_INIT)
    ) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (sp_dec),
        .load_init (sp_init),
        .sp        (sp_out)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_ENT1;
            ST_ENT1:    state_nx = ST_ENT2;
            ST_ENT2:    state_nx = ST_PUSH_HI;
            ST_PUSH_HI: state_nx = ST_PUSH_LO;
            ST_PUSH_LO: state_nx = ST_PUSH_ST;
            ST_PUSH_ST: state_nx = ST_VEC_LO;
            ST_VEC_LO:  state_nx = ST_VEC_HI;
            ST_VEC_HI:  state_nx = ST_IDLE;
        endcase
    end

    // Context captured at acceptance, vector low byte captured mid-sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= SRC_RESET;
            pc_q     <= '0;
            st_hi_q  <= '0;
            st_lo_q  <= '0;
            vec_lo_q <= '0;
        end else begin
            if (idle && accept) begin
                src_q   <= sel_src;
                pc_q    <= pc_in;
                st_hi_q <= stat_in[7:6];
                st_lo_q <= stat_in[3:0];
            end
            if (state == ST_VEC_LO)
                vec_lo_q <= vec_data;
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_RESET: vec_base = VEC_RESET;
            SRC_NMI:   vec_base = VEC_NMI;
            SRC_IRQ:   vec_base = VEC_IRQ;
            SRC_BRK:   vec_base = VEC_IRQ;
        endcase
    end

    always_comb begin
        pushed_status          = {st_hi_q, 2'b00, st_lo_q};
        pushed_status[ONE_BIT] = 1'b1;
        pushed_status[BRK_BIT] = (src_q == SRC_BRK);
    end

    // Output logic
    always_comb begin
        push_en   = 1'b0;
        push_data = '0;
        vec_rd    = 1'b0;
        vec_addr  = vec_base;
        set_i     = 1'b0;
        pc_load   = 1'b0;
        sp_init   = 1'b0;
        unique case (state)
            ST_IDLE, ST_ENT1, ST_ENT2: ;
            ST_PUSH_HI: begin
                push_en   = (src_q != SRC_RESET);
                push_data = pc_q[AW-1 -: DW];
            end
            ST_PUSH_LO: begin
                push_en   = (src_q != SRC_RESET);
                push_data = pc_q[DW-1:0];
            end
            ST_PUSH_ST: begin
                push_en   = (src_q != SRC_RESET);
                push_data = pushed_status;
                sp_init   = (src_q == SRC_RESET);
            end
            ST_VEC_LO: begin
                vec_rd = 1'b1;
                set_i  = 1'b1;
            end
            ST_VEC_HI: begin
                vec_rd      = 1'b1;
                vec_addr[0] = 1'b1;
                pc_load     = 1'b1;
            end
        endcase
    end

    assign sp_dec    = push_en;
    assign push_addr = {STACK_PAGE, sp_out};
    assign busy      = !idle;
    assign pc_new    = {vec_data, vec_lo_q};

endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk
    import intr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        push_en,
    input logic [15:0] push_addr,
    input logic [7:0]  sp_out,
    input logic        set_i,
    input logic        vec_rd,
    input logic [15:0] vec_addr,
    input logic        pc_load,
    input logic        insn_done,
    input logic        flag_i,
    input logic        accept,
    input intr_src_t   sel_src,
    input intr_src_t   src_q
);

    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (busy)
            run_q <= (run_q == 4'hF) ? run_q : run_q + 1'b1;
        else
            run_q <= '0;
    end

    p_entry_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (run_q == 4'd6));

    p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 4'd7));

    p_stack_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (push_addr[15:8] == 8'h01));

    p_sp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(push_en) |-> (sp_out == $past(sp_out) - 8'd1));

    p_vec_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (vec_rd && vec_addr[0] && $past(vec_rd) && !$past(vec_addr[0])));

    p_seti_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !set_i && pc_load);

    p_reset_nopush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_q == SRC_RESET) |-> !push_en);

    p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_src == SRC_IRQ) |-> !flag_i);

    p_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_src != SRC_RESET) |-> insn_done);

    p_vec_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd || push_en) |-> busy);

endmodule

bind intr_entry_seq intr_entry_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .push_en   (push_en),
    .push_addr (push_addr),
    .sp_out    (sp_out),
    .set_i     (set_i),
    .vec_rd    (vec_rd),
    .vec_addr  (vec_addr),
    .pc_load   (pc_load),
    .insn_done (insn_done),
    .flag_i    (flag_i),
    .accept    (accept),
    .sel_src   (sel_src),
    .src_q     (src_q)
);

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam int E_NONE = 0;
    localparam int E_RST  = 1;
    localparam int E_NMI  = 2;
    localparam int E_IRQ  = 3;
    localparam int E_BRK  = 4;

    typedef struct packed {
        logic       rst;
        logic       nmi;
        logic       irq;
        logic       ifl;
        logic       nen;
        logic       brk;
        logic [2:0] exp;
    } vec_t;

    // R1 R3 R4 R8 R11 scenarios
    localparam vec_t TBL [10] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},  // IRQ unmasked
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},  // IRQ masked
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2},  // NMI ignores I
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},  // NMI gated off
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4},  // break ignores I
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd2},  // NMI over IRQ
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1},  // reset over NMI
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2},  // leftover NMI
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3},  // IRQ over break
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1}   // reset alone
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_reset = 1'b0, req_nmi = 1'b0, req_irq = 1'b0;
    logic        flag_i = 1'b0, nmi_en = 1'b0, insn_done = 1'b0, brk_req = 1'b0;
    logic [15:0] pc_in = 16'h0;
    logic [7:0]  stat_in = 8'hDB;
    logic        push_en, set_i, vec_rd, busy, pc_load;
    logic [15:0] push_addr, vec_addr, pc_new;
    logic [7:0]  push_data, sp_out, vec_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] sp_model = 8'hFD;
    bit mid_nmi = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign vec_data = vec_addr[7:0] + 8'h11;

    intr_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_nmi(req_nmi),
        .req_irq(req_irq), .flag_i(flag_i), .nmi_en(nmi_en),
        .insn_done(insn_done), .brk_req(brk_req), .pc_in(pc_in),
        .stat_in(stat_in), .push_en(push_en), .push_addr(push_addr),
        .push_data(push_data), .sp_out(sp_out), .set_i(set_i),
        .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_data(vec_data),
        .busy(busy), .pc_load(pc_load), .pc_new(pc_new)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at the falling edge just after the accept edge
    task automatic run_entry(input int exp, input logic [15:0] pc, input logic [7:0] st);
        logic [15:0] base;
        logic [7:0]  exp_st;
        int pushes = 0;
        int bad_push = 0;
        int bad_seti = 0;
        int bad_busy = 0;
        if (exp == E_NONE) begin
            chk(busy == 1'b0, "R3/R4/R5 no entry", busy, 0);
            return;
        end
        base = (exp == E_NMI) ? 16'hFFFA : (exp == E_RST) ? 16'hFFFC : 16'hFFFE;
        exp_st = (st & 8'hCF) | 8'h20 | ((exp == E_BRK) ? 8'h10 : 8'h00);
        for (int i = 0; i < 7; i++) begin
            if (mid_nmi && i == 1) req_nmi = 1'b1;
            if (mid_nmi && i == 2) req_nmi = 1'b0;
            if (!busy) bad_busy++;
            if (set_i != (i == 5)) bad_seti++;
            if (push_en) begin
                pushes++;
                if (exp == E_RST || i < 2 || i > 4) bad_push++;
                else begin
                    if (push_addr != {8'h01, sp_model}) bad_push++;
                    if (i == 2 && push_data != pc[15:8]) bad_push++;
                    if (i == 3 && push_data != pc[7:0]) bad_push++;
                    if (i == 4) chk(push_data == exp_st, "R8 pushed status", push_data, exp_st);
                    sp_model = sp_model - 8'd1;
                end
            end
            if (i == 5) chk(vec_rd && vec_addr == base, "R2 vector low addr", vec_addr, base);
            if (i == 6) begin
                chk(vec_rd && vec_addr == (base | 16'h1), "R2 vector high addr", vec_addr, base | 16'h1);
                chk(pc_load == 1'b1, "R6 pc_load in cycle 7", pc_load, 1);
                chk(pc_new == {base[7:0] + 8'h12, base[7:0] + 8'h11}, "R2 handler address",
                    pc_new, {base[7:0] + 8'h12, base[7:0] + 8'h11});
            end
            @(negedge clk);
        end
        chk(bad_busy == 0 && busy == 1'b0, "R6 busy length", bad_busy, 0);
        chk(bad_seti == 0, "R10 set_i pulse", bad_seti, 0);
        chk(bad_push == 0, "R7 push order/address", bad_push, 0);
        if (exp == E_RST) begin
            sp_model = 8'hFD;
            chk(pushes == 0 && sp_out == 8'hFD, "R9 reset entry sp", sp_out, 8'hFD);
        end else begin
            chk(pushes == 3, "R7 push count", pushes, 3);
        end
        chk(sp_out == sp_model, "R7 sp after entry", sp_out, sp_model);
    endtask

    task automatic do_case(input vec_t v, input logic [15:0] pc);
        @(negedge clk);
        req_reset = v.rst; req_nmi = v.nmi; req_irq = v.irq;
        flag_i = v.ifl; nmi_en = v.nen; pc_in = pc; stat_in = 8'hDB;
        insn_done = 1'b0; brk_req = 1'b0;
        @(negedge clk);
        req_reset = 1'b0; req_nmi = 1'b0; insn_done = 1'b1; brk_req = v.brk;
        @(negedge clk);
        insn_done = 1'b0; brk_req = 1'b0; req_irq = 1'b0;
        run_entry(int'(v.exp), pc, 8'hDB);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9 reset state busy", busy, 0);
        chk(sp_out == 8'hFD, "R9 reset state sp", sp_out, 8'hFD);
        chk(push_en == 1'b0 && pc_load == 1'b0, "R9 reset state strobes", push_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_entry(E_RST, 16'h0, 8'hDB);  // R9 power-on entry

        foreach (TBL[k]) do_case(TBL[k], 16'h1230 + 16'(k));

        // R5: IRQ without a boundary strobe is not accepted
        @(negedge clk);
        req_irq = 1'b1; flag_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R5 no boundary no entry", busy, 0);
        req_irq = 1'b0;

        // R4: held-high NMI gives one entry only
        @(negedge clk);
        nmi_en = 1'b1; req_nmi = 1'b1; pc_in = 16'hABCD;
        @(negedge clk); insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0;
        run_entry(E_NMI, 16'hABCD, 8'hDB);
        insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0;
        chk(busy == 1'b0, "R4 single NMI per edge", busy, 0);
        req_nmi = 1'b0;

        // R11: NMI arriving during an IRQ entry is held
        @(negedge clk);
        req_irq = 1'b1; pc_in = 16'h4455;
        @(negedge clk); insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0; req_irq = 1'b0;
        mid_nmi = 1'b1;
        run_entry(E_IRQ, 16'h4455, 8'hDB);
        mid_nmi = 1'b0;
        chk(busy == 1'b0, "R11 idle before boundary", busy, 0);
        pc_in = 16'h5566;
        insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0;
        run_entry(E_NMI, 16'h5566, 8'hDB);  // R11 held NMI taken

        // R7: stack pointer wraps from 00 to FF
        for (int n = 0; n < 90; n++)
            do_case('{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3}, 16'h7000 + 16'(n));
        chk(sp_out == sp_model, "R7 sp wrap", sp_out, sp_model);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule